// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency setting a clock generator's PLL runs at. At power-up it captures a 5-bit strap code once, the first time the active-low power-good input is seen low, and raises the clock-enable output at that moment. From then on it picks the active setting from one of four places. These are the captured strap code, a select code held in the register file, a programmed N/M divider pair, and a recovery setting used while the watchdog holds the block in recovery mode.

The outputs are a gear/ratio index, the N and M divider values, and a flag that says whether N/M are in use. A one-cycle pulse marks every change of the applied setting. When enabled, an active-low reset pulse of a parameterised width also follows every change; it stands in for an open-drain pin. The register file is seen as a set of level inputs, so a write shows up as a change of value. While recovery is active, writes that would move the frequency are ignored. An N/M pair whose ratio (N+3)/(M+3) is not above one is never applied. It raises an error flag and leaves the previous setting in place.

Top module: `freq_src_sel`

## Requirements
- R1: The strap code is captured on the first clock edge at which `pwr_good_n` is 0; `clk_en` rises in the cycle after that edge and stays 1. Later changes of `strap_code` or `pwr_good_n` have no effect on the outputs.
- R2: With `prog_en`=0 and no recovery, `gear_idx` equals `sel_code` when `override`=1 and the captured strap code when `override`=0; `use_nm` is 0 and `n_out`, `m_out` are 0.
- R3: With `prog_en`=1 and no recovery, `use_nm`=1, `n_out`=`prog_n`, `m_out`=`prog_m`, and `gear_idx` still follows the `override` choice between `sel_code` and the strap code.
- R4: A candidate with `use_nm`=1 and N<=M (so (N+3)<=(M+3)) is not applied: `nm_err` becomes 1 and all outputs keep their values. The next applied valid candidate clears `nm_err` to 0.
- R5: Every change of the applied setting updates the outputs one cycle after the input change and raises `freq_chg` for exactly that cycle. Rewriting an unchanged value gives no pulse, and the first load after strap capture gives no pulse.
- R6: When `rst_on_chg` is 1 at the change, `sys_rst_n` is 0 for exactly RST_CYC cycles, starting in the cycle where `freq_chg` is 1. When `rst_on_chg` is 0, `sys_rst_n` stays 1.
- R7: When `recovery` rises, the setting becomes the strap code with `use_nm`=0 if `rec_sel`=0. If `rec_sel`=1 it becomes `rec_n`/`rec_m` with `use_nm`=1, and the gear index is chosen by `override`.
- R8: While `recovery` stays 1, changes to any register input leave the outputs unchanged with no `freq_chg`. After `recovery` falls, the normal selection of R2/R3 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good_n | input | 1 | Active-low power-good; first low captures the strap code |
| strap_code | input | 5 | Strap pins giving the power-up frequency index |
| override | input | 1 | 1 = take the index from `sel_code`, 0 = from the strap code |
| sel_code | input | 5 | Register-programmed frequency index |
| prog_en | input | 1 | 1 = use the programmed N/M pair |
| prog_n | input | 8 | Programmed N value |
| prog_m | input | 7 | Programmed M value |
| rec_sel | input | 1 | Recovery source: 0 = strap code, 1 = recovery N/M |
| rec_n | input | 8 | Recovery N value |
| rec_m | input | 7 | Recovery M value |
| rst_on_chg | input | 1 | Enable reset pulse on frequency change |
| recovery | input | 1 | Recovery mode from the watchdog |
| clk_en | output | 1 | All clock outputs enabled |
| gear_idx | output | 5 | Applied gear/ratio index |
| n_out | output | 8 | Applied N value |
| m_out | output | 7 | Applied M value |
| use_nm | output | 1 | 1 = PLL uses N/M |
| freq_chg | output | 1 | One-cycle pulse on a change of the applied setting |
| nm_err | output | 1 | Last candidate had an invalid N/M ratio |
| sys_rst_n | output | 1 | Active-low system reset pulse |

## Verification
The selection is tried with override both off and on, and with a strap code and a select code chosen to differ. A wrong source is then visible in the gear index. Programmed pairs are checked with N well above M, with N equal to M and with N below M, which separates a strict from a non-strict ratio test. A rewrite of an identical value must show that no spurious event fires. Recovery is entered once with each recovery source, while register inputs keep changing inside the window. This tells a true lock-out apart from one that only blocks some fields.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  localparam int IDX_W = 5;
  localparam int N_W   = 8;
  localparam int M_W   = 7;

  typedef struct packed {
    logic [IDX_W-1:0] gear;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
    logic             use_nm;
  } freq_cfg_t;

  function automatic logic ratio_ok(input freq_cfg_t c);
    return !c.use_nm || (c.n > {{(N_W-M_W){1'b0}}, c.m});
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_good_n,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] strap_q,
  output logic         strap_vld
);
  logic         take;
  logic [W-1:0] strap_d;
  logic         vld_d;

  always_comb begin
    take    = !strap_vld && !pwr_good_n;
    strap_d = take ? strap_in : strap_q;
    vld_d   = strap_vld | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q   <= '0;
      strap_vld <= 1'b0;
    end else begin
      strap_q   <= strap_d;
      strap_vld <= vld_d;
    end
  end
endmodule

// File: rtl/cfg_arbiter.sv
module cfg_arbiter
  import freq_sel_pkg::*;
(
  input  logic             override,
  input  logic [IDX_W-1:0] sel_code,
  input  logic [IDX_W-1:0] strap_q,
  input  logic             prog_en,
  input  logic [N_W-1:0]   prog_n,
  input  logic [M_W-1:0]   prog_m,
  input  logic             rec_sel,
  input  logic [N_W-1:0]   rec_n,
  input  logic [M_W-1:0]   rec_m,
  input  logic             recovery,
  output freq_cfg_t        cand
);
  logic [IDX_W-1:0] idx_src;

  always_comb begin
    idx_src = override ? sel_code : strap_q;
    cand    = '0;
    if (recovery) begin
      if (rec_sel) begin
        cand.gear   = idx_src;
        cand.n      = rec_n;
        cand.m      = rec_m;
        cand.use_nm = 1'b1;
      end else begin
        cand.gear   = strap_q;
      end
    end else begin
      cand.gear = idx_src;
      if (prog_en) begin
        cand.n      = prog_n;
        cand.m      = prog_m;
        cand.use_nm = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int RST_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_n
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)            cnt_d = LOAD;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel
  import freq_sel_pkg::*;
#(
  parameter int RST_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good_n,
  input  logic [4:0] strap_code,
  input  logic       override,
  input  logic [4:0] sel_code,
  input  logic       prog_en,
  input  logic [7:0] prog_n,
  input  logic [6:0] prog_m,
  input  logic       rec_sel,
  input  logic [7:0] rec_n,
  input  logic [6:0] rec_m,
  input  logic       rst_on_chg,
  input  logic       recovery,
  output logic       clk_en,
  output logic [4:0] gear_idx,
  output logic [7:0] n_out,
  output logic [6:0] m_out,
  output logic       use_nm,
  output logic       freq_chg,
  output logic       nm_err,
  output logic       sys_rst_n
);
  logic [IDX_W-1:0] strap_q;
  logic             strap_vld;
  freq_cfg_t        cand;
  freq_cfg_t        cur_q, cur_d;
  logic             init_q, init_d;
  logic             rec_q;
  logic             err_q, err_d;
  logic             chg_q, chg_d;
  logic             eval_en;

  strap_capture #(.W(IDX_W)) u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good_n(pwr_good_n),
    .strap_in  (strap_code),
    .strap_q   (strap_q),
    .strap_vld (strap_vld)
  );

  cfg_arbiter u_arb (
    .override(override),
    .sel_code(sel_code),
    .strap_q (strap_q),
    .prog_en (prog_en),
    .prog_n  (prog_n),
    .prog_m  (prog_m),
    .rec_sel (rec_sel),
    .rec_n   (rec_n),
    .rec_m   (rec_m),
    .recovery(recovery),
    .cand    (cand)
  );

  // Evaluate normally, or once on recovery entry; hold while locked.
  always_comb begin
    eval_en = strap_vld && (!recovery || !rec_q);
    cur_d   = cur_q;
    err_d   = err_q;
    chg_d   = 1'b0;
    init_d  = init_q | eval_en;
    if (eval_en) begin
      if (ratio_ok(cand)) begin
        cur_d = cand;
        err_d = 1'b0;
        chg_d = init_q && (cand != cur_q);
      end else begin
        err_d = 1'b1;
        if (!init_q) begin
          cur_d      = '0;
          cur_d.gear = cand.gear;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      init_q <= 1'b0;
      rec_q  <= 1'b0;
      err_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      init_q <= init_d;
      rec_q  <= recovery && strap_vld;
      err_q  <= err_d;
      chg_q  <= chg_d;
    end
  end

  rst_pulse_gen #(.RST_CYC(RST_CYC)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (chg_d && rst_on_chg),
    .pulse_n(sys_rst_n)
  );

  assign clk_en   = strap_vld;
  assign gear_idx = cur_q.gear;
  assign n_out    = cur_q.n;
  assign m_out    = cur_q.m;
  assign use_nm   = cur_q.use_nm;
  assign freq_chg = chg_q;
  assign nm_err   = err_q;
endmodule

// File: rtl/freq_src_sel_chk.sv
module freq_src_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_en,
  input logic [4:0] gear_idx,
  input logic [7:0] n_out,
  input logic [6:0] m_out,
  input logic       use_nm,
  input logic       freq_chg,
  input logic       sys_rst_n,
  input logic       rst_on_chg,
  input logic       recovery,
  input logic       rec_q
);
  AST_CLKEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |=> clk_en);  // R1

  AST_NO_EVENT_BEFORE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |-> !freq_chg);  // R5

  AST_NM_RATIO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    use_nm |-> (n_out > {1'b0, m_out}));  // R4

  AST_EVENT_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    freq_chg |-> ({gear_idx, n_out, m_out, use_nm} !=
                  $past({gear_idx, n_out, m_out, use_nm})));  // R5

  AST_RESET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_chg && $past(rst_on_chg)) |-> !sys_rst_n);  // R6

  AST_RECOVERY_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (recovery && rec_q) |=> (!freq_chg && $stable({gear_idx, n_out, m_out, use_nm})));  // R8
endmodule

bind freq_src_sel freq_src_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_en    (clk_en),
  .gear_idx  (gear_idx),
  .n_out     (n_out),
  .m_out     (m_out),
  .use_nm    (use_nm),
  .freq_chg  (freq_chg),
  .sys_rst_n (sys_rst_n),
  .rst_on_chg(rst_on_chg),
  .recovery  (recovery),
  .rec_q     (rec_q)
);

// File: tb/test_freq_src_sel.sv
module test_freq_src_sel;
  localparam int RST_CYC = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwr_good_n;
  logic [4:0] strap_code;
  logic       override;
  logic [4:0] sel_code;
  logic       prog_en;
  logic [7:0] prog_n;
  logic [6:0] prog_m;
  logic       rec_sel;
  logic [7:0] rec_n;
  logic [6:0] rec_m;
  logic       rst_on_chg;
  logic       recovery;
  logic       clk_en;
  logic [4:0] gear_idx;
  logic [7:0] n_out;
  logic [6:0] m_out;
  logic       use_nm;
  logic       freq_chg;
  logic       nm_err;
  logic       sys_rst_n;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  freq_src_sel #(.RST_CYC(RST_CYC)) i_freq_src_sel (.*);

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic chk_cfg(input string req, input logic [4:0] g, input logic [7:0] n,
                         input logic [6:0] m, input logic u);
    chk(req, "gear_idx", 32'(gear_idx), 32'(g));
    chk(req, "n_out",    32'(n_out),    32'(n));
    chk(req, "m_out",    32'(m_out),    32'(m));
    chk(req, "use_nm",   32'(use_nm),   32'(u));
  endtask

  task automatic t_reset;
    chk("R1", "clk_en after reset", 32'(clk_en), 0);
    chk("R6", "sys_rst_n after reset", 32'(sys_rst_n), 1);
    chk("R5", "freq_chg after reset", 32'(freq_chg), 0);
  endtask

  task automatic t_strap;
    step(3);
    chk("R1", "clk_en before power-good", 32'(clk_en), 0);
    pwr_good_n = 1'b0;
    step(1);
    chk("R1", "clk_en after capture", 32'(clk_en), 1);
    strap_code = 5'h04;
    step(1);
    chk_cfg("R1", 5'h13, 8'd0, 7'd0, 1'b0);
    chk("R5", "no event on first load", 32'(freq_chg), 0);
    pwr_good_n = 1'b1;
    step(2);
    pwr_good_n = 1'b0;
    step(2);
    chk("R1", "strap not recaptured", 32'(gear_idx), 32'h13);
    chk("R1", "clk_en stays", 32'(clk_en), 1);
  endtask

  task automatic t_override;
    sel_code = 5'h0A;
    step(1);
    chk("R2", "sel ignored without override", 32'(gear_idx), 32'h13);
    override = 1'b1;
    step(1);
    chk_cfg("R2", 5'h0A, 8'd0, 7'd0, 1'b0);
    chk("R5", "event on change", 32'(freq_chg), 1);
    chk("R6", "no reset when disabled", 32'(sys_rst_n), 1);
    step(1);
    chk("R5", "event lasts one cycle", 32'(freq_chg), 0);
  endtask

  task automatic t_prog;
    prog_n = 8'd100; prog_m = 7'd45; prog_en = 1'b1;
    step(1);
    chk_cfg("R3", 5'h0A, 8'd100, 7'd45, 1'b1);
    override = 1'b0;
    step(1);
    chk_cfg("R3", 5'h13, 8'd100, 7'd45, 1'b1);
    step(1);
    prog_n = 8'd100;
    step(1);
    chk("R5", "rewrite same value no event", 32'(freq_chg), 0);
  endtask

  task automatic t_bad_nm;
    prog_n = 8'd40;
    step(1);
    chk("R4", "err on N<M", 32'(nm_err), 1);
    chk_cfg("R4", 5'h13, 8'd100, 7'd45, 1'b1);
    chk("R4", "no event on reject", 32'(freq_chg), 0);
    prog_n = 8'd45;
    step(1);
    chk("R4", "err on N==M", 32'(nm_err), 1);
    chk("R4", "N kept on N==M", 32'(n_out), 100);
    prog_n = 8'd46;
    step(1);
    chk("R4", "err cleared", 32'(nm_err), 0);
    chk("R4", "N applied", 32'(n_out), 46);
    chk("R5", "event on valid load", 32'(freq_chg), 1);
  endtask

  task automatic t_rst_pulse;
    int lows = 0;
    rst_on_chg = 1'b1;
    prog_n = 8'd60;
    step(1);
    chk("R6", "freq_chg with pulse", 32'(freq_chg), 1);
    chk("R6", "reset asserted at event", 32'(sys_rst_n), 0);
    for (int i = 0; i < RST_CYC + 4; i++) begin
      if (!sys_rst_n) lows++;
      step(1);
    end
    chk("R6", "reset pulse width", 32'(lows), 32'(RST_CYC));
    rst_on_chg = 1'b0;
    prog_n = 8'd70;
    step(1);
    chk("R6", "no pulse when disabled", 32'(sys_rst_n), 1);
  endtask

  task automatic t_recovery;
    rec_sel = 1'b0;
    recovery = 1'b1;
    step(1);
    chk_cfg("R7", 5'h13, 8'd0, 7'd0, 1'b0);
    chk("R7", "event on recovery entry", 32'(freq_chg), 1);
    prog_n = 8'd90; override = 1'b1; sel_code = 5'h1F; rec_sel = 1'b1;
    rec_n = 8'd150; rec_m = 7'd93;
    step(1);
    chk_cfg("R8", 5'h13, 8'd0, 7'd0, 1'b0);
    chk("R8", "no event while locked", 32'(freq_chg), 0);
    prog_en = 1'b0;
    step(2);
    chk_cfg("R8", 5'h13, 8'd0, 7'd0, 1'b0);
    recovery = 1'b0;
    step(1);
    chk_cfg("R8", 5'h1F, 8'd0, 7'd0, 1'b0);
    sel_code = 5'h0A;
    step(1);
    recovery = 1'b1;
    step(1);
    chk_cfg("R7", 5'h0A, 8'd150, 7'd93, 1'b1);
    recovery = 1'b0;
    step(1);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; pwr_good_n = 1'b1; strap_code = 5'h13;
        override = 1'b0; sel_code = 5'h00; prog_en = 1'b0;
        prog_n = 8'd0; prog_m = 7'd0; rec_sel = 1'b0; rec_n = 8'd0;
        rec_m = 7'd0; rst_on_chg = 1'b0; recovery = 1'b0;
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_strap();
        t_override();
        t_prog();
        t_bad_nm();
        t_rst_pulse();
        t_recovery();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule